// File: doc/BRIEF.md
# Line Driver Supervisory Controller

This block is the clocked supervisor for a single-wire industrial line driver. The local controller drives an enable and a transmit level. The block turns them into gate controls for a high-side (sourcing) switch and a low-side (sinking) switch, and never turns both on together. The analog front end reports four digital flags: the driver is in current limit, the line is high, the die is above the shutdown temperature, and the die is above the warning temperature. It also reports whether the die is above the re-enable temperature. Every one of these inputs is asynchronous, so each passes through a two-flop synchronizer before use.

The block measures how long a current-limit episode lasts, counted in clock cycles. A master wake-up request looks like a current-limit episode of bounded length while the line sits at the level opposite to the one being driven. A short glitch is ignored. An episode that outlasts the window is a sustained overcurrent, and it is reported on the current-ok flag. A thermal shutdown turns the driver off from any state. A hysteretic temperature-ok flag warns the controller before shutdown and stays asserted until the die has cooled.

Each status flag is an open-drain output. It appears at the ports as two signals: an active-low pull-down enable, and a released (high-impedance) indication.

Top module: `lineDrvSupervisor`

## Requirements
- R1: While enable is low, both switch controls are off, whatever the transmit level.
- R2: While enable is high and no fault is active, transmit 0 turns on only the high-side switch, and transmit 1 turns on only the low-side switch. Both switches are never on together.
- R3: A current-limit episode lasting fewer than WAKE_MIN_CYC synchronized cycles never asserts wake. An episode lasting more than WAKE_MAX_CYC cycles never asserts wake either.
- R4: From the transmit state, a current-limit episode of N cycles with WAKE_MIN_CYC <= N <= WAKE_MAX_CYC asserts wake (pull-down on, released 0), provided the line sense was opposite to the driven level in the last limited cycle. The driven level is high when transmit is 0, and the line sense bit reads 1 when the line is high. Once asserted, wake holds until enable goes low or a thermal shutdown occurs. During that time the driver keeps following transmit and further current-limit episodes are ignored.
- R5: An episode inside the window whose line sense equals the driven level does not assert wake.
- R6: When a current-limit episode reaches cycle WAKE_MAX_CYC+1, current-ok is pulled low and wake stays released. The switch selected by transmit stays on.
- R7: When current limit clears in the fault state, current-ok is released and normal transmit resumes.
- R8: Enable low in the transmit, wake or fault state returns the block to receive-only, with wake and current-ok released.
- R9: A shutdown-temperature flag forces both switches off from any state and releases wake and current-ok. The block leaves shutdown only when the die is below the re-enable level, and then it follows enable and transmit again.
- R10: Temperature-ok is pulled low when the die is above the warning level or above the shutdown level. It stays low until the die is below the re-enable level, and only then is it released.
- R11: A synchronous active-low reset puts the block in receive-only, with both switches off and every flag released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| enIn | input | 1 | Driver enable from the local controller (async) |
| txIn | input | 1 | Transmit level from the local controller (async) |
| curLimIn | input | 1 | Driver-in-current-limit flag (async) |
| lineHighIn | input | 1 | Receiver comparator, 1 = line high (async) |
| overTempIn | input | 1 | Die above shutdown temperature (async) |
| tempWarnIn | input | 1 | Die above warning temperature (async) |
| tempHotIn | input | 1 | Die above re-enable temperature (async) |
| hsOn | output | 1 | High-side (sourcing) switch on |
| lsOn | output | 1 | Low-side (sinking) switch on |
| wakeDrvN | output | 1 | Wake pull-down enable, active low |
| wakeRelZ | output | 1 | Wake flag released |
| curOkDrvN | output | 1 | Current-ok pull-down enable, active low |
| curOkRelZ | output | 1 | Current-ok flag released |
| tempOkDrvN | output | 1 | Temperature-ok pull-down enable, active low |
| tempOkRelZ | output | 1 | Temperature-ok flag released |

## Verification
The bench builds the block with WAKE_MIN_CYC = 6 and WAKE_MAX_CYC = 10 in place of the multi-thousand-cycle defaults. With these values, episodes of exactly 5, 6, 10 and 11 cycles can be driven in a short run, which exercises both edges of the wake window. A held overcurrent reaches the fault state within a few dozen cycles. The same values leave room for the full thermal sequence: warning, shutdown, cooling through the re-enable level, and recovery.

// File: rtl/lineDrvPkg.sv
package lineDrvPkg;

  typedef enum logic [2:0] {
    ST_RX,
    ST_TX,
    ST_WAKE,
    ST_FAULT,
    ST_THERM
  } drvState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic drvOn;
    logic wakeAct;
    logic faultAct;
    logic cntRun;
  } ctrlStrobe_t;

  // synchronized conditions from datapath to control
  typedef struct packed {
    logic en;
    logic lim;
    logic tsd;
    logic hot;
    logic reachMin;
    logic reachMax;
    logic lineOpp;
  } dpStatus_t;

endpackage

// File: rtl/lineDrvSync.sv
module lineDrvSync #(
  parameter int WIDTH = 1,
  parameter int DEPTH = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stages [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) stages[s] <= RST_VAL;
        else       stages[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) stages[s] <= RST_VAL;
        else       stages[s] <= stages[s-1];
      end
    end
  end

  assign dout = stages[DEPTH-1];
endmodule

// File: rtl/lineDrvDatapath.sv
module lineDrvDatapath
  import lineDrvPkg::*;
#(
  parameter int WAKE_MIN_CYC = 3000,
  parameter int WAKE_MAX_CYC = 5000,
  parameter int SYNC_DEPTH   = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enIn,
  input  logic        txIn,
  input  logic        curLimIn,
  input  logic        lineHighIn,
  input  logic        overTempIn,
  input  logic        tempWarnIn,
  input  logic        tempHotIn,
  input  ctrlStrobe_t strobe,
  output dpStatus_t   status,
  output logic        hsOn,
  output logic        lsOn,
  output logic        wakeDrvN,
  output logic        wakeRelZ,
  output logic        curOkDrvN,
  output logic        curOkRelZ,
  output logic        tempOkDrvN,
  output logic        tempOkRelZ
);
  localparam int NUM_IN = 7;
  localparam int CW     = $clog2(WAKE_MAX_CYC + 1);
  localparam logic [CW-1:0] MIN_VAL = CW'(WAKE_MIN_CYC);
  localparam logic [CW-1:0] MAX_VAL = CW'(WAKE_MAX_CYC);
  // bit order: en, tx, lim, line, tsd, warn, hot; tx resets high (sinking side)
  localparam logic [NUM_IN-1:0] SYNC_RST = 7'b0100000;

  logic [NUM_IN-1:0] rawIn, syncIn;
  logic enS, txS, limS, lineS, tsdS, warnS, hotS;
  logic [CW-1:0] limCnt;
  logic oppLast;
  logic tempLow;

  assign rawIn = {enIn, txIn, curLimIn, lineHighIn, overTempIn, tempWarnIn, tempHotIn};

  lineDrvSync #(.WIDTH(NUM_IN), .DEPTH(SYNC_DEPTH), .RST_VAL(SYNC_RST)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (rawIn),
    .dout (syncIn)
  );

  assign {enS, txS, limS, lineS, tsdS, warnS, hotS} = syncIn;

  // duration of the current episode, saturating at the upper window edge
  always_ff @(posedge clk) begin
    if (!rstN || !strobe.cntRun || !limS) limCnt <= '0;
    else if (limCnt != MAX_VAL)           limCnt <= limCnt + 1'b1;
  end

  // line opposite to driven level: driving high when tx = 0, so opposite line = tx
  always_ff @(posedge clk) begin
    if (!rstN)     oppLast <= 1'b0;
    else if (limS) oppLast <= (lineS == txS);
  end

  // temperature flag with hysteresis between warning and re-enable levels
  always_ff @(posedge clk) begin
    if (!rstN)               tempLow <= 1'b0;
    else if (warnS || tsdS)  tempLow <= 1'b1;
    else if (!hotS)          tempLow <= 1'b0;
  end

  always_comb begin
    status.en       = enS;
    status.lim      = limS;
    status.tsd      = tsdS;
    status.hot      = hotS;
    status.reachMin = (limCnt >= MIN_VAL);
    status.reachMax = (limCnt == MAX_VAL);
    status.lineOpp  = oppLast;
  end

  assign hsOn       = strobe.drvOn & ~txS;
  assign lsOn       = strobe.drvOn &  txS;
  assign wakeDrvN   = ~strobe.wakeAct;
  assign wakeRelZ   = ~strobe.wakeAct;
  assign curOkDrvN  = ~strobe.faultAct;
  assign curOkRelZ  = ~strobe.faultAct;
  assign tempOkDrvN = ~tempLow;
  assign tempOkRelZ = ~tempLow;
endmodule

// File: rtl/lineDrvCtrl.sv
module lineDrvCtrl
  import lineDrvPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe
);
  drvState_e state, stateNxt;

  always_comb begin
    stateNxt = state;
    if (status.tsd) begin
      stateNxt = ST_THERM;
    end else begin
      unique case (state)
        ST_RX:    if (status.en) stateNxt = ST_TX;
        ST_TX: begin
          if (!status.en)                             stateNxt = ST_RX;
          else if (status.lim && status.reachMax)     stateNxt = ST_FAULT;
          else if (!status.lim && status.reachMin && status.lineOpp)
                                                      stateNxt = ST_WAKE;
        end
        ST_WAKE:  if (!status.en) stateNxt = ST_RX;
        ST_FAULT: begin
          if (!status.en)       stateNxt = ST_RX;
          else if (!status.lim) stateNxt = ST_TX;
        end
        ST_THERM: if (!status.hot) stateNxt = status.en ? ST_TX : ST_RX;
        default:  stateNxt = ST_RX;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RX;
    else       state <= stateNxt;
  end

  always_comb begin
    strobe.drvOn    = (state == ST_TX) || (state == ST_WAKE) || (state == ST_FAULT);
    strobe.wakeAct  = (state == ST_WAKE);
    strobe.faultAct = (state == ST_FAULT);
    strobe.cntRun   = (state == ST_TX);
  end
endmodule

// File: rtl/lineDrvSupervisor.sv
module lineDrvSupervisor
  import lineDrvPkg::*;
#(
  parameter int WAKE_MIN_CYC = 3000,
  parameter int WAKE_MAX_CYC = 5000,
  parameter int SYNC_DEPTH   = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic enIn,
  input  logic txIn,
  input  logic curLimIn,
  input  logic lineHighIn,
  input  logic overTempIn,
  input  logic tempWarnIn,
  input  logic tempHotIn,
  output logic hsOn,
  output logic lsOn,
  output logic wakeDrvN,
  output logic wakeRelZ,
  output logic curOkDrvN,
  output logic curOkRelZ,
  output logic tempOkDrvN,
  output logic tempOkRelZ
);
  ctrlStrobe_t strobe;
  dpStatus_t   status;

  lineDrvCtrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .status (status),
    .strobe (strobe)
  );

  lineDrvDatapath #(
    .WAKE_MIN_CYC (WAKE_MIN_CYC),
    .WAKE_MAX_CYC (WAKE_MAX_CYC),
    .SYNC_DEPTH   (SYNC_DEPTH)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .enIn       (enIn),
    .txIn       (txIn),
    .curLimIn   (curLimIn),
    .lineHighIn (lineHighIn),
    .overTempIn (overTempIn),
    .tempWarnIn (tempWarnIn),
    .tempHotIn  (tempHotIn),
    .strobe     (strobe),
    .status     (status),
    .hsOn       (hsOn),
    .lsOn       (lsOn),
    .wakeDrvN   (wakeDrvN),
    .wakeRelZ   (wakeRelZ),
    .curOkDrvN  (curOkDrvN),
    .curOkRelZ  (curOkRelZ),
    .tempOkDrvN (tempOkDrvN),
    .tempOkRelZ (tempOkRelZ)
  );
endmodule

// File: rtl/lineDrvChecker.sv
module lineDrvChecker (
  input logic clk,
  input logic rstN,
  input logic enIn,
  input logic overTempIn,
  input logic hsOn,
  input logic lsOn,
  input logic wakeDrvN,
  input logic wakeRelZ,
  input logic curOkDrvN,
  input logic curOkRelZ,
  input logic tempOkDrvN
);
  // edges since reset release, saturating; gates lookbacks through the synchronizer
  logic [2:0] sinceRst;
  always_ff @(posedge clk) begin
    if (!rstN)                 sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 1'b1;
  end

  a_r2_no_shoot_through: assert property (@(posedge clk) disable iff (!rstN)
    !(hsOn && lsOn));

  // R8 / R1: enable low three edges ago means receive-only now
  a_r8_enable_low_idle: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd3 && $past(enIn, 3) == 1'b0)
      |-> (!hsOn && !lsOn && wakeRelZ && curOkRelZ));

  a_r9_shutdown_off: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd3 && $past(overTempIn, 3))
      |-> (!hsOn && !lsOn && wakeRelZ && curOkRelZ && !tempOkDrvN));

  a_r6_fault_keeps_driver: assert property (@(posedge clk) disable iff (!rstN)
    !curOkDrvN |-> (hsOn || lsOn));

  a_r3_wake_fault_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(!wakeDrvN && !curOkDrvN));

  // R4: wake is only dropped on the way to receive-only or shutdown
  a_r4_wake_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeDrvN) |-> (!hsOn && !lsOn));
endmodule

bind lineDrvSupervisor lineDrvChecker u_chk (.*);

// File: tb/lineDrvSupervisor_tb.sv
module lineDrvSupervisor_tb;
  localparam int WMIN   = 6;
  localparam int WMAX   = 10;
  localparam int SETTLE = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enIn = 1'b0, txIn = 1'b1, curLimIn = 1'b0, lineHighIn = 1'b0;
  logic overTempIn = 1'b0, tempWarnIn = 1'b0, tempHotIn = 1'b0;
  logic hsOn, lsOn, wakeDrvN, wakeRelZ, curOkDrvN, curOkRelZ, tempOkDrvN, tempOkRelZ;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    string      tag;
    logic [7:0] exp;
  } expItem_t;
  expItem_t expQ[$];

  always #10 clk = ~clk;

  lineDrvSupervisor #(.WAKE_MIN_CYC(WMIN), .WAKE_MAX_CYC(WMAX)) u_dut (
    .clk(clk), .rstN(rstN), .enIn(enIn), .txIn(txIn), .curLimIn(curLimIn),
    .lineHighIn(lineHighIn), .overTempIn(overTempIn), .tempWarnIn(tempWarnIn),
    .tempHotIn(tempHotIn), .hsOn(hsOn), .lsOn(lsOn), .wakeDrvN(wakeDrvN),
    .wakeRelZ(wakeRelZ), .curOkDrvN(curOkDrvN), .curOkRelZ(curOkRelZ),
    .tempOkDrvN(tempOkDrvN), .tempOkRelZ(tempOkRelZ)
  );

  // expected pin image: {hs, ls, wakeDrvN, wakeRelZ, curOkDrvN, curOkRelZ, tempOkDrvN, tempOkRelZ}
  function automatic logic [7:0] mk(logic hs, logic ls, logic wake, logic fault, logic hot);
    return {hs, ls, ~wake, ~wake, ~fault, ~fault, ~hot, ~hot};
  endfunction

  // monitor: pops expectations and compares against the pins
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t it;
      logic [7:0] obs;
      it  = expQ.pop_front();
      obs = {hsOn, lsOn, wakeDrvN, wakeRelZ, curOkDrvN, curOkRelZ, tempOkDrvN, tempOkRelZ};
      checks++;
      if (obs !== it.exp) begin
        failures++;
        $display("FAIL %s actual=%b expected=%b", it.tag, obs, it.exp);
      end
    end
  end

  task automatic expectAfter(string tag, int waitCyc, logic [7:0] exp);
    expItem_t it;
    repeat (waitCyc) @(negedge clk);
    it.tag = tag;
    it.exp = exp;
    expQ.push_back(it);
    wait (expQ.size() == 0);
    @(negedge clk);
  endtask

  // drive n limited cycles; opp selects line level opposite to the driven one
  task automatic limPulse(int n, bit opp);
    @(negedge clk);
    curLimIn   = 1'b1;
    lineHighIn = opp ? txIn : ~txIn;
    repeat (n) @(negedge clk);
    curLimIn   = 1'b0;
    lineHighIn = ~txIn;
  endtask

  task automatic setDrive(logic en, logic tx);
    @(negedge clk);
    enIn = en;
    txIn = tx;
    lineHighIn = ~tx;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expectAfter("R11 reset state", 1, mk(0, 0, 0, 0, 0));

    // R1: transmit ignored while disabled
    setDrive(1'b0, 1'b0);
    expectAfter("R1 en=0 tx=0", SETTLE, mk(0, 0, 0, 0, 0));
    setDrive(1'b0, 1'b1);
    expectAfter("R1 en=0 tx=1", SETTLE, mk(0, 0, 0, 0, 0));

    // R2: switch selection
    setDrive(1'b1, 1'b0);
    expectAfter("R2 tx=0 high-side", SETTLE, mk(1, 0, 0, 0, 0));
    setDrive(1'b1, 1'b1);
    expectAfter("R2 tx=1 low-side", SETTLE, mk(0, 1, 0, 0, 0));

    // R3 lower edge: one cycle short of the window
    limPulse(WMIN - 1, 1'b1);
    expectAfter("R3 short episode", SETTLE, mk(0, 1, 0, 0, 0));

    // R4 lower edge
    limPulse(WMIN, 1'b1);
    expectAfter("R4 min episode wakes", SETTLE, mk(0, 1, 1, 0, 0));
    setDrive(1'b1, 1'b0);
    expectAfter("R4 wake held, driver follows tx", SETTLE, mk(1, 0, 1, 0, 0));
    setDrive(1'b0, 1'b0);
    expectAfter("R8 enable low clears wake", SETTLE, mk(0, 0, 0, 0, 0));

    // R4 upper edge, driving high
    setDrive(1'b1, 1'b0);
    expectAfter("R2 re-enable high-side", SETTLE, mk(1, 0, 0, 0, 0));
    limPulse(WMAX, 1'b1);
    expectAfter("R4 max episode wakes", SETTLE, mk(1, 0, 1, 0, 0));
    setDrive(1'b0, 1'b0);
    expectAfter("R8 idle after wake", SETTLE, mk(0, 0, 0, 0, 0));
    setDrive(1'b1, 1'b0);
    expectAfter("R8 re-enable no wake", SETTLE, mk(1, 0, 0, 0, 0));

    // R5: line at driven level
    limPulse(WMIN + 1, 1'b0);
    expectAfter("R5 same-level episode ignored", SETTLE, mk(1, 0, 0, 0, 0));

    // R3 upper edge: one cycle too long
    limPulse(WMAX + 1, 1'b1);
    expectAfter("R3 long episode no wake", SETTLE, mk(1, 0, 0, 0, 0));

    // R6 / R7: sustained overcurrent
    @(negedge clk);
    curLimIn = 1'b1;
    lineHighIn = 1'b0;
    expectAfter("R6 fault pulls current-ok", WMAX + 7, mk(1, 0, 0, 1, 0));
    curLimIn = 1'b0;
    lineHighIn = 1'b1;
    expectAfter("R7 fault cleared", SETTLE, mk(1, 0, 0, 0, 0));

    // R8 from fault
    @(negedge clk);
    curLimIn = 1'b1;
    expectAfter("R6 fault again", WMAX + 7, mk(1, 0, 0, 1, 0));
    enIn = 1'b0;
    expectAfter("R8 enable low clears fault", SETTLE, mk(0, 0, 0, 0, 0));
    curLimIn = 1'b0;

    // R9 / R10: shutdown sequence from wake
    setDrive(1'b1, 1'b1);
    limPulse(WMIN, 1'b1);
    expectAfter("R4 wake before heating", SETTLE, mk(0, 1, 1, 0, 0));
    tempWarnIn = 1'b1;
    tempHotIn  = 1'b1;
    expectAfter("R10 warning pulls temp-ok", SETTLE, mk(0, 1, 1, 0, 1));
    overTempIn = 1'b1;
    expectAfter("R9 shutdown forces off", SETTLE, mk(0, 0, 0, 0, 1));
    overTempIn = 1'b0;
    expectAfter("R9 still above re-enable", SETTLE, mk(0, 0, 0, 0, 1));
    tempWarnIn = 1'b0;
    expectAfter("R10 held low in recovery", SETTLE, mk(0, 0, 0, 0, 1));
    tempHotIn = 1'b0;
    expectAfter("R9 R10 recovered to transmit", SETTLE, mk(0, 1, 0, 0, 0));

    // R10 hysteresis without shutdown
    tempWarnIn = 1'b1;
    tempHotIn  = 1'b1;
    expectAfter("R10 warn only", SETTLE, mk(0, 1, 0, 0, 1));
    tempWarnIn = 1'b0;
    expectAfter("R10 between levels stays low", SETTLE, mk(0, 1, 0, 0, 1));
    tempHotIn = 1'b0;
    expectAfter("R10 released when cool", SETTLE, mk(0, 1, 0, 0, 0));

    // R11: reset while in fault
    @(negedge clk);
    curLimIn = 1'b1;
    expectAfter("R6 fault before reset", WMAX + 7, mk(0, 1, 0, 1, 0));
    rstN = 1'b0;
    expectAfter("R11 reset in fault", 2, mk(0, 0, 0, 0, 0));
    curLimIn = 1'b0;
    enIn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    expectAfter("R11 idle after reset", SETTLE, mk(0, 0, 0, 0, 0));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule